// File: doc/BRIEF.md
# Dual-Protocol Two-Wire Serial Master

This block is a bus master for a shared two-wire line pair: one clock line and one data line. Both lines are open-drain with pull-ups. A single shift engine runs either of two protocols on the same pins. The first is a management-frame protocol that moves 16-bit words to and from a register selected by a 5-bit device number and a 5-bit register number. The second is a slow byte protocol in which every byte is followed by an acknowledge slot.

A command strobe starts one read or write transfer. The protocol for that transfer is taken from a configuration input at the moment the transfer is accepted. A `busy` flag covers the whole transfer. A one-cycle `done` pulse marks the end, with the read word and a not-acknowledged flag valid at that point. While a transfer runs, a separate indicator pin shows which protocol is on the wire.

Top module: `twowire_dual_master`

## Requirements
- R1: `cfg_lowspeed` is sampled only when a command is accepted (1 selects the byte protocol, 0 selects the management protocol). Changing it during a transfer has no effect on that transfer.
- R2: `proto_ind` is 1 during a byte-protocol transfer and 0 during a management transfer. It is 0 whenever `busy` is 0.
- R3: The block never drives a line high. `scl_oe` and `sda_oe` only pull the line low. Both are 0 while idle, so both lines float high.
- R4: A management frame has 64 clock rises. Its bits, in this order, are: 32 ones, the start pair 0 then 1, the opcode (1,0 for read; 0,1 for write), `cmd_dev[4:0]` MSB first, `cmd_reg` MSB first, a turnaround pair, and 16 data bits MSB first. For a write, the turnaround is 1 then 0 and the data is `cmd_wdata`.
- R5: In a management read, the data line is released for the turnaround and the 16 data bits. The data bits are sampled while the clock is high, and `rdata` holds the word at `done`.
- R6: A byte transfer has these parts, in order: START (data falls while the clock is high), the byte {`cmd_dev`, R/W} MSB first with R/W = 1 for read, an acknowledge slot, a data byte, a second acknowledge slot, and STOP (data rises while the clock is high). A write sends `cmd_wdata[7:0]`. A read releases the line for the data byte and for the second slot, and returns {8'h00, byte} in `rdata`.
- R7: If the line reads high in the address acknowledge slot, or in the data acknowledge slot of a write, `nack` is set and STOP follows at once. For an address NACK, this gives 10 clock rises in total.
- R8: `busy` rises in the cycle after an accepted `cmd_valid` and falls when the bus is released. A `cmd_valid` while `busy` is 1 is ignored.
- R9: Each bit time is four quarter periods with the clock low in the first half and high in the second half. A quarter lasts `Q_MGMT` clocks in management mode and `Q_LOW` clocks in byte mode. The defaults of 1 and 63 give 25 MHz and about 397 kbit/s from 100 MHz.
- R10: `done` is a one-cycle pulse in the cycle where `busy` falls. `rdata` and `nack` hold their values until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lowspeed | input | 1 | Protocol select, sampled at command accept |
| cmd_valid | input | 1 | Start a transfer |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | 7 | Device number (byte mode uses 7 bits, management mode uses the low 5) |
| cmd_reg | input | 5 | Management register number |
| cmd_wdata | input | 16 | Write data (byte mode uses the low 8 bits) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 16 | Read result |
| nack | output | 1 | Target did not acknowledge |
| scl_oe | output | 1 | Pull clock line low |
| sda_oe | output | 1 | Pull data line low |
| sda_in | input | 1 | Data line level |
| proto_ind | output | 1 | Active-protocol indicator |

## Verification
The bench goes after these corner cases:
- An address NACK. A design that does not jump to STOP keeps clocking and returns more than 10 rises.
- A data NACK on a write. A design that ignores it leaves `nack` low.
- A read with a single 1 in the last data bit. This catches an off-by-one in the sample point or in the shift direction.
- A command and a protocol-select change arriving in the middle of a transfer. A design that re-samples either would corrupt the captured frame, flip the indicator, or produce an extra `done`.

Measuring the time between clock rises in each mode catches a divider that reloads from the wrong mode.

// File: rtl/twowire_dual_master.sv
module twowire_dual_master #(
  parameter int Q_MGMT = 1,
  parameter int Q_LOW  = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_lowspeed,
  input  logic        cmd_valid,
  input  logic        cmd_read,
  input  logic [6:0]  cmd_dev,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        nack,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in,
  output logic        proto_ind
);
  localparam int QMAX = (Q_LOW > Q_MGMT) ? Q_LOW : Q_MGMT;
  localparam int QW   = $clog2(QMAX + 1);
  localparam logic [6:0] LAST_M = 7'd63;
  localparam logic [6:0] LAST_L = 7'd19;

  logic          proto, rd;
  logic [6:0]    dev;
  logic [4:0]    rg;
  logic [15:0]   wd;
  logic [6:0]    bidx;
  logic [1:0]    q;
  logic [QW-1:0] qcnt, qreload;
  logic          scl_v, sda_v, last;

  wire [63:0] mframe = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, dev[4:0], rg,
                        rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
  wire [7:0]  abyte  = {dev, rd};
  wire        qend   = busy && (qcnt == '0);

  always_comb begin
    scl_v = q[1];
    sda_v = 1'b1;
    last  = 1'b0;
    if (!proto) begin
      sda_v = mframe[6'(7'd63 - bidx)];
      last  = (bidx == LAST_M);
    end else if (bidx == 7'd0) begin
      scl_v = 1'b1;
      sda_v = ~q[1];
    end else if (bidx <= 7'd8) begin
      sda_v = abyte[3'(7'd8 - bidx)];
    end else if (bidx >= 7'd10 && bidx <= 7'd17) begin
      sda_v = rd | wd[3'(7'd17 - bidx)];
    end else if (bidx == LAST_L) begin
      scl_v = (q != 2'd0);
      sda_v = q[1];
      last  = 1'b1;
    end
  end

  assign scl_oe    = busy & ~scl_v;
  assign sda_oe    = busy & ~sda_v;
  assign proto_ind = busy & proto;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; proto <= 1'b0; rd <= 1'b0;
      dev <= '0; rg <= '0; wd <= '0; bidx <= '0; q <= '0;
      qcnt <= '0; qreload <= '0; rdata <= '0; nack <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy    <= 1'b1;
          proto   <= cfg_lowspeed;
          qreload <= cfg_lowspeed ? QW'(Q_LOW - 1) : QW'(Q_MGMT - 1);
          qcnt    <= cfg_lowspeed ? QW'(Q_LOW - 1) : QW'(Q_MGMT - 1);
          rd <= cmd_read; dev <= cmd_dev; rg <= cmd_reg; wd <= cmd_wdata;
          bidx <= '0; q <= '0; rdata <= '0; nack <= 1'b0;
        end
      end else if (!qend) begin
        qcnt <= qcnt - 1'b1;
      end else begin
        qcnt <= qreload;
        q    <= q + 1'b1;
        if (q == 2'd2) begin
          if (rd && ((!proto && bidx >= 7'd48) ||
                     (proto && bidx >= 7'd10 && bidx <= 7'd17)))
            rdata <= {rdata[14:0], sda_in};
          if (proto && sda_in && (bidx == 7'd9 || (bidx == 7'd18 && !rd)))
            nack <= 1'b1;
        end
        if (q == 2'd3) begin
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else if (proto && nack) begin
            bidx <= LAST_L;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
      end
    end
  end
endmodule

module twd_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cmd_valid,
  input logic proto_ind,
  input logic scl_oe,
  input logic sda_oe
);
  assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sda_oe && !scl_oe));
  assert_ind_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !proto_ind);
  assert_ind_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(proto_ind));
  assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (busy || done));
endmodule

bind twowire_dual_master twd_checker chk (.*);

// File: tb/test_twowire_dual_master.sv
module test_twowire_dual_master;
  localparam int QM = 1;
  localparam int QL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_lowspeed = 1'b0, cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [6:0] cmd_dev = '0;
  logic [4:0] cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, done, nack, scl_oe, sda_oe, proto_ind;
  logic [15:0] rdata;
  logic tgt_low = 1'b0;
  wire  sda_line = !(sda_oe || tgt_low);
  wire  scl_line = !scl_oe;

  always #5 clk = ~clk;

  twowire_dual_master #(.Q_MGMT(QM), .Q_LOW(QL)) i_twowire_dual_master (
    .clk(clk), .rst_n(rst_n), .cfg_lowspeed(cfg_lowspeed), .cmd_valid(cmd_valid),
    .cmd_read(cmd_read), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rdata(rdata), .nack(nack), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_line), .proto_ind(proto_ind));

  typedef struct {
    logic        ls;
    int          nbits;
    logic [63:0] bits;
    logic [15:0] rd;
    logic        nk;
  } item_t;
  item_t sb[$];

  int checks = 0, fails = 0, cyc = 0;
  logic t_ls = 0, t_rd = 0, t_ackA = 1, t_ackD = 1;
  logic [15:0] t_pat = '0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int nfall = 0, ncap = 0, r1 = 0, r2 = 0;
  logic [63:0] cap = '0;
  logic prev_scl = 1'b1, prev_busy = 1'b0, ind_bad = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (busy && !prev_busy) begin
      nfall = 0; ncap = 0; cap = '0; ind_bad = 1'b0;
    end
    if (busy && prev_scl && !scl_line) nfall++;
    if (busy && !prev_scl && scl_line) begin
      cap = {cap[62:0], sda_line};
      ncap++;
      if (ncap == 1) r1 = cyc;
      if (ncap == 2) r2 = cyc;
    end
    if (busy && proto_ind !== t_ls) ind_bad = 1'b1;
    begin
      int b;
      logic low;
      low = 1'b0;
      b = t_ls ? nfall : nfall - 1;
      if (busy) begin
        if (!t_ls && t_rd && b >= 48 && b <= 63) low = !t_pat[63 - b];
        if (t_ls && b == 9) low = t_ackA;
        if (t_ls && !t_rd && b == 18) low = t_ackD;
        if (t_ls && t_rd && b >= 10 && b <= 17) low = !t_pat[17 - b];
      end
      tgt_low <= low;
    end
    if (done) begin
      if (sb.size() == 0) check("R10 unexpected done", 1, 0);
      else begin
        item_t e;
        e = sb.pop_front();
        check("R4/R6 rise count", 64'(ncap), 64'(e.nbits));
        check("R4/R6/R7 frame bits", cap & ((64'd1 << e.nbits) - 1),
              e.bits & ((64'd1 << e.nbits) - 1));
        check("R5/R6 rdata", 64'(rdata), 64'(e.rd));
        check("R7 nack", 64'(nack), 64'(e.nk));
        check("R2 indicator", 64'(ind_bad), 64'(0));
        check("R9 bit period", 64'(r2 - r1), 64'(4 * (e.ls ? QL : QM)));
      end
    end
    prev_scl  = scl_line;
    prev_busy = busy;
  end

  task automatic issue(input logic ls, input logic rd, input logic [6:0] dev,
                       input logic [4:0] rg, input logic [15:0] wd, input logic ackA,
                       input logic ackD, input logic [15:0] pat, input logic disturb);
    item_t e;
    e.ls = ls; e.nk = 0; e.rd = '0;
    if (!ls) begin
      e.nbits = 64;
      e.bits = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, dev[4:0], rg,
                rd ? 2'b11 : 2'b10, rd ? pat : wd};
      if (rd) e.rd = pat;
    end else if (!ackA) begin
      e.nbits = 10; e.bits = 64'({dev, rd, 1'b1, 1'b0}); e.nk = 1;
    end else if (rd) begin
      e.nbits = 19; e.bits = 64'({dev, 1'b1, 1'b0, pat[7:0], 1'b1, 1'b0});
      e.rd = {8'h00, pat[7:0]};
    end else begin
      e.nbits = 19; e.bits = 64'({dev, 1'b0, 1'b0, wd[7:0], !ackD, 1'b0});
      e.nk = !ackD;
    end
    sb.push_back(e);
    t_ls = ls; t_rd = rd; t_ackA = ackA; t_ackD = ackD; t_pat = pat;
    @(negedge clk);
    cfg_lowspeed = ls; cmd_read = rd; cmd_dev = dev; cmd_reg = rg; cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (disturb) begin
      repeat (20) @(negedge clk);
      cfg_lowspeed = !ls; cmd_read = !rd; cmd_dev = ~dev; cmd_wdata = ~wd; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R8 idle after done", 64'(busy), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset lines released", 64'({sda_oe, scl_oe}), 64'(0));
    check("R8 reset busy", 64'({busy, done}), 64'(0));
    check("R2 reset indicator", 64'(proto_ind), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    issue(0, 0, 7'h13, 5'h0A, 16'hBEEF, 1, 1, 16'h0, 0);
    issue(0, 1, 7'h01, 5'h02, 16'h0, 1, 1, 16'hA5C3, 0);
    issue(0, 1, 7'h1F, 5'h1F, 16'h0, 1, 1, 16'h0001, 0);
    issue(1, 0, 7'h50, 5'h00, 16'h003C, 1, 1, 16'h0, 0);
    issue(1, 1, 7'h2B, 5'h00, 16'h0, 1, 1, 16'h0096, 0);
    issue(1, 0, 7'h44, 5'h00, 16'h00F0, 0, 1, 16'h0, 0);
    issue(1, 0, 7'h45, 5'h00, 16'h005A, 1, 0, 16'h0, 0);
    issue(0, 0, 7'h0C, 5'h15, 16'h1234, 1, 1, 16'h0, 1);
    issue(1, 1, 7'h7F, 5'h00, 16'h0, 1, 1, 16'h0001, 1);
    check("R1/R8 scoreboard drained", 64'(sb.size()), 64'(0));
    check("R10 rdata held after done", 64'(rdata), 64'h0001);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule